// File: doc/BRIEF.md
# Exception Entry Sequencer

This controller sits beside a processor core and carries out the entry into an exception handler. It watches four request sources: a maskable interrupt that arrives with its own vector number, a non-maskable interrupt, a break trap with a programmable vector number and a bus fault with a supplied vector number. When it accepts a request it takes a snapshot of the program counter, the status word, the stack pointer and the pending delay-slot offset. From that snapshot it produces write strobes and data for the special registers that the core keeps outside this block.

The entry sequence works as follows. The return address goes to the normal return register, or to a separate return register for non-maskable entries. When the exception hit a delay slot, the saved return address is moved back by the delay-slot offset. The status word is pushed one level on its in-word flag stack. The vector number is recorded in an exception-status register. When the core was in user mode, the user stack pointer is saved and the kernel stack pointer is loaded. Last, the handler address is read from the vector table over a single-word read port with a valid/ready request and a data-valid response, and that address is written into the program counter.

The sequencer is a five-state machine. IDLE accepts a request and goes to SAVE. SAVE issues all register writes in one cycle and goes to FETCH. FETCH holds the read request until ready and then goes to WAIT_RDATA. WAIT_RDATA waits for read data and then goes to DONE. DONE writes the PC, pulses done and goes back to IDLE.

Top module: `exc_entry_seq`

## Requirements
- R1: A maskable interrupt is taken only if its request is high, the interrupt-enable bit (bit 4) of the status word is 1 and the lock input is 0. Otherwise no entry starts and no register strobe fires.
- R2: A non-maskable interrupt is taken only if the status bit M (bit 30) is 1. On entry it uses vector 0, writes the PC to the NMI return register (not the normal one) and writes a status word with bit 30 cleared.
- R3: Break uses the trap vector input, bus fault uses the fault vector input and a maskable interrupt uses its request vector. All three write the PC to the normal return register.
- R4: The exception-status write carries the 8-bit vector in bits [15:8] and zeros in all other bits.
- R5: If the delay-slot offset loaded through the delay-slot load strobe is non-zero at entry, the saved normal return address is PC minus that offset, and the offset is cleared by the entry.
- R6: If the user-mode bit (bit 5) of the status word is 1 at entry, the old stack pointer is written to the user stack register and the kernel stack value is written to the stack pointer. Otherwise neither is written.
- R7: The new status word is old[31:30] in bits [31:30], old[19:0] in bits [29:10] and zeros in bits [9:0].
- R8: The read address is exception base + 4 × vector. The word returned is written to the PC.
- R9: Priority at acceptance is bus fault, then break, then maskable interrupt, then non-maskable interrupt.
- R10: The read request and its address stay stable until ready is seen.
- R11: PC write and done form a single one-cycle pulse, after which the controller is idle.
- R12: Requests that arrive while the controller is busy are ignored. Each accepted request produces exactly one entry.
- R13: Synchronous reset returns the controller to IDLE with all strobes low and clears the stored delay-slot offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| irq_req_i | input | 1 | Maskable interrupt request |
| irq_vec_i | input | 8 | Vector number of the maskable interrupt |
| irq_lock_i | input | 1 | Interrupt lock; blocks maskable interrupts |
| nmi_req_i | input | 1 | Non-maskable interrupt request |
| brk_req_i | input | 1 | Break trap request |
| trap_vec_i | input | 8 | Programmable break vector number |
| fault_req_i | input | 1 | Bus fault request |
| fault_vec_i | input | 8 | Bus fault vector number |
| dslot_ld_i | input | 1 | Load strobe for the delay-slot offset |
| dslot_val_i | input | 3 | Delay-slot offset value |
| pc_i | input | 32 | Current program counter |
| ccs_i | input | 32 | Current status word |
| sp_i | input | 32 | Current stack pointer |
| ksp_i | input | 32 | Kernel stack pointer value |
| ebp_i | input | 32 | Exception vector table base |
| erp_we_o | output | 1 | Normal return register write |
| erp_wdata_o | output | 32 | Normal return register data |
| nrp_we_o | output | 1 | NMI return register write |
| nrp_wdata_o | output | 32 | NMI return register data |
| exs_we_o | output | 1 | Exception-status register write |
| exs_wdata_o | output | 32 | Exception-status register data |
| ccs_we_o | output | 1 | Status word write |
| ccs_wdata_o | output | 32 | Pushed status word |
| usp_we_o | output | 1 | User stack register write |
| usp_wdata_o | output | 32 | User stack register data |
| sp_we_o | output | 1 | Stack pointer write |
| sp_wdata_o | output | 32 | Stack pointer data |
| rd_req_o | output | 1 | Vector table read request |
| rd_addr_o | output | 32 | Vector table read address |
| rd_ready_i | input | 1 | Read request accepted |
| rd_rvalid_i | input | 1 | Read data valid |
| rd_rdata_i | input | 32 | Read data |
| pc_we_o | output | 1 | Program counter write |
| pc_wdata_o | output | 32 | New program counter (handler address) |
| done_o | output | 1 | One-cycle entry-complete pulse |
| busy_o | output | 1 | Controller not in IDLE |

## Verification
The assertions check these properties on every cycle:
- the exception-status word format and the cleared low bits of the pushed status word;
- NMI entries strobe only the NMI return register;
- the stack swap always uses the kernel value;
- read request and address stay stable while waiting for ready;
- the done pulse is one cycle long;
- an interrupt that is disabled or locked leaves the machine idle.

Only the bench scenarios can show the values themselves, because they depend on the snapshot taken at acceptance:
- the vector chosen when several sources fire together;
- the delay-slot rewind and its clearing after use and after reset;
- the exact status-word shift;
- the table address;
- requests dropped during a busy entry.

// File: rtl/exc_pkg.sv
package exc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SAVE,
        ST_FETCH,
        ST_WAIT_RDATA,
        ST_DONE
    } exc_state_e;

    typedef enum logic [1:0] {
        CLS_IRQ,
        CLS_NMI,
        CLS_BRK,
        CLS_FLT
    } exc_cls_e;

endpackage

// File: rtl/exc_req_arbiter.sv
module exc_req_arbiter
    import exc_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int VEC_W  = 8,
    parameter int IE_BIT = 4,
    parameter int M_BIT  = 30
) (
    input  logic             enable_i,
    input  logic             irq_req_i,
    input  logic             irq_lock_i,
    input  logic             nmi_req_i,
    input  logic             brk_req_i,
    input  logic             fault_req_i,
    input  logic [XLEN-1:0]  ccs_i,
    input  logic [VEC_W-1:0] irq_vec_i,
    input  logic [VEC_W-1:0] trap_vec_i,
    input  logic [VEC_W-1:0] fault_vec_i,
    output logic             take_o,
    output exc_cls_e         cls_o,
    output logic [VEC_W-1:0] vec_o
);

    logic irq_ok;
    logic nmi_ok;

    // gating: enable flag set and no lock for maskable, M flag for non-maskable
    assign irq_ok = irq_req_i && ccs_i[IE_BIT] && !irq_lock_i;
    assign nmi_ok = nmi_req_i && ccs_i[M_BIT];

    // fixed priority: fault, break, maskable, non-maskable
    always_comb begin
        take_o = 1'b0;
        cls_o  = CLS_IRQ;
        vec_o  = '0;
        if (fault_req_i) begin
            take_o = enable_i;
            cls_o  = CLS_FLT;
            vec_o  = fault_vec_i;
        end else if (brk_req_i) begin
            take_o = enable_i;
            cls_o  = CLS_BRK;
            vec_o  = trap_vec_i;
        end else if (irq_ok) begin
            take_o = enable_i;
            cls_o  = CLS_IRQ;
            vec_o  = irq_vec_i;
        end else if (nmi_ok) begin
            take_o = enable_i;
            cls_o  = CLS_NMI;
            vec_o  = '0;
        end
    end

endmodule

// File: rtl/exc_flag_stack.sv
module exc_flag_stack #(
    parameter int XLEN      = 32,
    parameter int KEEP_W    = 2,
    parameter int SHIFT_W   = 10,
    parameter int M_BIT     = 30
) (
    input  logic [XLEN-1:0] ccs_i,
    input  logic            clr_m_i,
    output logic [XLEN-1:0] ccs_o
);

    localparam int LOW_W = XLEN - KEEP_W - SHIFT_W;

    logic [XLEN-1:0] masked;

    always_comb begin
        masked = ccs_i;
        if (clr_m_i) begin
            masked[M_BIT] = 1'b0;
        end
    end

    generate
        if (SHIFT_W == 0) begin : g_noshift
            assign ccs_o = masked;
        end else begin : g_shift
            // top bits kept, low field moved up one level, lowest level emptied
            assign ccs_o = {masked[XLEN-1 -: KEEP_W], masked[LOW_W-1:0], {SHIFT_W{1'b0}}};
        end
    endgenerate

endmodule

// File: rtl/exc_ctx_calc.sv
module exc_ctx_calc #(
    parameter int XLEN    = 32,
    parameter int VEC_W   = 8,
    parameter int DS_W    = 3,
    parameter int EXS_LSB = 8
) (
    input  logic [XLEN-1:0]  pc_i,
    input  logic [DS_W-1:0]  dslot_i,
    input  logic [VEC_W-1:0] vec_i,
    input  logic [XLEN-1:0]  ebp_i,
    output logic [XLEN-1:0]  ret_addr_o,
    output logic [XLEN-1:0]  exs_o,
    output logic [XLEN-1:0]  tbl_addr_o
);

    localparam int EXS_HI_W = XLEN - VEC_W - EXS_LSB;
    localparam int IDX_PAD  = XLEN - VEC_W - 2;

    assign ret_addr_o = pc_i - {{(XLEN-DS_W){1'b0}}, dslot_i};
    assign exs_o      = {{EXS_HI_W{1'b0}}, vec_i, {EXS_LSB{1'b0}}};
    assign tbl_addr_o = ebp_i + {{IDX_PAD{1'b0}}, vec_i, 2'b00};

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int VEC_W     = 8,
    parameter int DS_W      = 3,
    parameter int IE_BIT    = 4,
    parameter int U_BIT     = 5,
    parameter int M_BIT     = 30,
    parameter int KEEP_W    = 2,
    parameter int SHIFT_W   = 10,
    parameter int EXS_LSB   = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             irq_req_i,
    input  logic [VEC_W-1:0] irq_vec_i,
    input  logic             irq_lock_i,
    input  logic             nmi_req_i,
    input  logic             brk_req_i,
    input  logic [VEC_W-1:0] trap_vec_i,
    input  logic             fault_req_i,
    input  logic [VEC_W-1:0] fault_vec_i,
    input  logic             dslot_ld_i,
    input  logic [DS_W-1:0]  dslot_val_i,
    input  logic [XLEN-1:0]  pc_i,
    input  logic [XLEN-1:0]  ccs_i,
    input  logic [XLEN-1:0]  sp_i,
    input  logic [XLEN-1:0]  ksp_i,
    input  logic [XLEN-1:0]  ebp_i,
    output logic             erp_we_o,
    output logic [XLEN-1:0]  erp_wdata_o,
    output logic             nrp_we_o,
    output logic [XLEN-1:0]  nrp_wdata_o,
    output logic             exs_we_o,
    output logic [XLEN-1:0]  exs_wdata_o,
    output logic             ccs_we_o,
    output logic [XLEN-1:0]  ccs_wdata_o,
    output logic             usp_we_o,
    output logic [XLEN-1:0]  usp_wdata_o,
    output logic             sp_we_o,
    output logic [XLEN-1:0]  sp_wdata_o,
    output logic             rd_req_o,
    output logic [XLEN-1:0]  rd_addr_o,
    input  logic             rd_ready_i,
    input  logic             rd_rvalid_i,
    input  logic [XLEN-1:0]  rd_rdata_i,
    output logic             pc_we_o,
    output logic [XLEN-1:0]  pc_wdata_o,
    output logic             done_o,
    output logic             busy_o
);

    exc_state_e       state_q, state_d;
    exc_cls_e         cls_q, arb_cls;
    logic             arb_take;
    logic [VEC_W-1:0] arb_vec, vec_q;
    logic [XLEN-1:0]  pc_q, ccs_q, sp_q, pc_new_q;
    logic [DS_W-1:0]  dslot_q, ds_snap_q;
    logic [XLEN-1:0]  ret_addr, exs_val, tbl_addr, ccs_pushed;

    exc_req_arbiter #(
        .XLEN   (XLEN),
        .VEC_W  (VEC_W),
        .IE_BIT (IE_BIT),
        .M_BIT  (M_BIT)
    ) u_arb (
        .enable_i    (state_q == ST_IDLE),
        .irq_req_i   (irq_req_i),
        .irq_lock_i  (irq_lock_i),
        .nmi_req_i   (nmi_req_i),
        .brk_req_i   (brk_req_i),
        .fault_req_i (fault_req_i),
        .ccs_i       (ccs_i),
        .irq_vec_i   (irq_vec_i),
        .trap_vec_i  (trap_vec_i),
        .fault_vec_i (fault_vec_i),
        .take_o      (arb_take),
        .cls_o       (arb_cls),
        .vec_o       (arb_vec)
    );

    exc_flag_stack #(
        .XLEN    (XLEN),
        .KEEP_W  (KEEP_W),
        .SHIFT_W (SHIFT_W),
        .M_BIT   (M_BIT)
    ) u_fstk (
        .ccs_i   (ccs_q),
        .clr_m_i (cls_q == CLS_NMI),
        .ccs_o   (ccs_pushed)
    );

    exc_ctx_calc #(
        .XLEN    (XLEN),
        .VEC_W   (VEC_W),
        .DS_W    (DS_W),
        .EXS_LSB (EXS_LSB)
    ) u_ctx (
        .pc_i       (pc_q),
        .dslot_i    (ds_snap_q),
        .vec_i      (vec_q),
        .ebp_i      (ebp_i),
        .ret_addr_o (ret_addr),
        .exs_o      (exs_val),
        .tbl_addr_o (tbl_addr)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (arb_take) state_d = ST_SAVE;
            ST_SAVE:       state_d = ST_FETCH;
            ST_FETCH:      if (rd_ready_i) state_d = ST_WAIT_RDATA;
            ST_WAIT_RDATA: if (rd_rvalid_i) state_d = ST_DONE;
            ST_DONE:       state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // entry snapshot, delay-slot offset and fetched handler address
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cls_q     <= CLS_IRQ;
            vec_q     <= '0;
            pc_q      <= '0;
            ccs_q     <= '0;
            sp_q      <= '0;
            ds_snap_q <= '0;
            dslot_q   <= '0;
            pc_new_q  <= '0;
        end else begin
            if (state_q == ST_IDLE && arb_take) begin
                cls_q     <= arb_cls;
                vec_q     <= arb_vec;
                pc_q      <= pc_i;
                ccs_q     <= ccs_i;
                sp_q      <= sp_i;
                ds_snap_q <= dslot_q;
            end
            if (state_q == ST_SAVE) begin
                dslot_q <= '0;
            end else if (dslot_ld_i) begin
                dslot_q <= dslot_val_i;
            end
            if (state_q == ST_WAIT_RDATA && rd_rvalid_i) begin
                pc_new_q <= rd_rdata_i;
            end
        end
    end

    // outputs per state
    always_comb begin
        erp_we_o    = 1'b0;
        nrp_we_o    = 1'b0;
        exs_we_o    = 1'b0;
        ccs_we_o    = 1'b0;
        usp_we_o    = 1'b0;
        sp_we_o     = 1'b0;
        rd_req_o    = 1'b0;
        pc_we_o     = 1'b0;
        done_o      = 1'b0;
        erp_wdata_o = ret_addr;
        nrp_wdata_o = pc_q;
        exs_wdata_o = exs_val;
        ccs_wdata_o = ccs_pushed;
        usp_wdata_o = sp_q;
        sp_wdata_o  = ksp_i;
        rd_addr_o   = tbl_addr;
        pc_wdata_o  = pc_new_q;
        busy_o      = (state_q != ST_IDLE);
        unique case (state_q)
            ST_IDLE: ;
            ST_SAVE: begin
                erp_we_o = (cls_q != CLS_NMI);
                nrp_we_o = (cls_q == CLS_NMI);
                exs_we_o = 1'b1;
                ccs_we_o = 1'b1;
                usp_we_o = ccs_q[U_BIT];
                sp_we_o  = ccs_q[U_BIT];
            end
            ST_FETCH:      rd_req_o = 1'b1;
            ST_WAIT_RDATA: ;
            ST_DONE: begin
                pc_we_o = 1'b1;
                done_o  = 1'b1;
            end
            default: ;
        endcase
    end

    // R1
    irq_gate_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!busy_o && irq_req_i && (!ccs_i[IE_BIT] || irq_lock_i)
         && !nmi_req_i && !brk_req_i && !fault_req_i) |=> !busy_o);

    // R2
    nmi_ret_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        nrp_we_o |-> (!erp_we_o && ccs_we_o && !ccs_wdata_o[M_BIT]));

    // R4
    exs_fmt_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        exs_we_o |-> (exs_wdata_o[EXS_LSB-1:0] == '0
                      && exs_wdata_o[XLEN-1:EXS_LSB+VEC_W] == '0));

    // R7
    ccs_low_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ccs_we_o |-> (ccs_wdata_o[SHIFT_W-1:0] == '0));

    // R6
    stack_swap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        sp_we_o |-> (usp_we_o && ccs_we_o && sp_wdata_o == ksp_i));

    // R8
    addr_align_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        rd_req_o |-> (rd_addr_o[1:0] == 2'b00));

    // R10
    req_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_req_o && !rd_ready_i) |=> (rd_req_o && $stable(rd_addr_o)));

    // R11
    done_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |=> (!done_o && !busy_o));

    // R11
    done_pc_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> pc_we_o);

    // R12
    busy_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_o && !done_o) |=> busy_o);

    // R13
    reset_idle_chk: assert property (@(posedge clk_i)
        rst_i |=> (!busy_o && !rd_req_o && !done_o));

endmodule

// File: tb/exc_entry_seq_test.sv
module exc_entry_seq_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        irq_req, irq_lock, nmi_req, brk_req, flt_req, ds_ld;
    logic [7:0]  irq_vec, trap_vec, fault_vec;
    logic [2:0]  ds_val;
    logic [31:0] pc, ccs, sp, ksp, ebp;
    logic        erp_we, nrp_we, exs_we, ccs_we, usp_we, sp_we, rd_req, pc_we, done, busy;
    logic [31:0] erp_wd, nrp_wd, exs_wd, ccs_wd, usp_wd, sp_wd, rd_addr, pc_wd;
    logic        rd_ready, rd_rvalid;
    logic [31:0] rd_rdata;

    int n_chk = 0, n_bad = 0;
    int n_entry = 0, n_done = 0, n_erp = 0, n_nrp = 0, n_usp = 0, n_sp = 0;
    logic [31:0] m_erp, m_nrp, m_exs, m_ccs, m_usp, m_sp, m_addr, m_pc;
    bit finished = 0;

    always #5 clk = ~clk;

    exc_entry_seq uut (
        .clk_i(clk), .rst_i(rst),
        .irq_req_i(irq_req), .irq_vec_i(irq_vec), .irq_lock_i(irq_lock),
        .nmi_req_i(nmi_req), .brk_req_i(brk_req), .trap_vec_i(trap_vec),
        .fault_req_i(flt_req), .fault_vec_i(fault_vec),
        .dslot_ld_i(ds_ld), .dslot_val_i(ds_val),
        .pc_i(pc), .ccs_i(ccs), .sp_i(sp), .ksp_i(ksp), .ebp_i(ebp),
        .erp_we_o(erp_we), .erp_wdata_o(erp_wd),
        .nrp_we_o(nrp_we), .nrp_wdata_o(nrp_wd),
        .exs_we_o(exs_we), .exs_wdata_o(exs_wd),
        .ccs_we_o(ccs_we), .ccs_wdata_o(ccs_wd),
        .usp_we_o(usp_we), .usp_wdata_o(usp_wd),
        .sp_we_o(sp_we), .sp_wdata_o(sp_wd),
        .rd_req_o(rd_req), .rd_addr_o(rd_addr),
        .rd_ready_i(rd_ready), .rd_rvalid_i(rd_rvalid), .rd_rdata_i(rd_rdata),
        .pc_we_o(pc_we), .pc_wdata_o(pc_wd),
        .done_o(done), .busy_o(busy)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {a[15:0], ~a[15:0]} ^ 32'h1357_9BDF;
    endfunction

    // port monitor: values present just before each rising edge
    always @(posedge clk) begin
        if (exs_we) begin n_entry++; m_exs = exs_wd; m_ccs = ccs_wd; end
        if (erp_we) begin n_erp++; m_erp = erp_wd; end
        if (nrp_we) begin n_nrp++; m_nrp = nrp_wd; end
        if (usp_we) begin n_usp++; m_usp = usp_wd; end
        if (sp_we)  begin n_sp++;  m_sp  = sp_wd;  end
        if (rd_req && rd_ready) m_addr = rd_addr;
        if (done && pc_we) begin n_done++; m_pc = pc_wd; end
    end

    // vector table responder
    initial begin
        int ph = 0;
        int dly = 0;
        logic [31:0] a = 0;
        rd_ready = 0; rd_rvalid = 0; rd_rdata = 0;
        forever begin
            @(negedge clk);
            rd_rvalid = 0;
            if (ph == 0) begin
                rd_ready = 0;
                if (rd_req && ($urandom % 3 != 0)) begin
                    rd_ready = 1; a = rd_addr; ph = 1;
                end
            end else if (ph == 1) begin
                rd_ready = 0;
                dly = $urandom % 3;
                if (dly == 0) begin rd_rvalid = 1; rd_rdata = mem_word(a); ph = 0; end
                else ph = 2;
            end else begin
                dly--;
                if (dly == 0) begin rd_rvalid = 1; rd_rdata = mem_word(a); ph = 0; end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // stimulus for one case
    bit t_irq, t_nmi, t_brk, t_flt, t_lock;
    logic [2:0] t_ds;

    task automatic do_case(input bit extra);
        int cls;
        logic [7:0] vec;
        logic [31:0] c, exp_ccs, exp_addr;
        int b_entry, b_done, b_erp, b_nrp, b_usp, b_sp;
        @(negedge clk);
        irq_lock = t_lock;
        if (t_ds != 0) begin
            ds_val = t_ds; ds_ld = 1;
            @(negedge clk);
            ds_ld = 0;
        end
        b_entry = n_entry; b_done = n_done; b_erp = n_erp;
        b_nrp = n_nrp; b_usp = n_usp; b_sp = n_sp;
        irq_req = t_irq; nmi_req = t_nmi; brk_req = t_brk; flt_req = t_flt;
        @(negedge clk);
        irq_req = 0; nmi_req = 0; brk_req = 0; flt_req = 0;
        if (extra) begin
            irq_req = 1; nmi_req = 1; brk_req = 1; flt_req = 1;
            @(negedge clk);
            irq_req = 0; nmi_req = 0; brk_req = 0; flt_req = 0;
        end
        // reference selection (R9 priority)
        cls = -1; vec = 0;
        if (t_flt) begin cls = 3; vec = fault_vec; end
        else if (t_brk) begin cls = 2; vec = trap_vec; end
        else if (t_irq && ccs[4] && !t_lock) begin cls = 0; vec = irq_vec; end
        else if (t_nmi && ccs[30]) begin cls = 1; vec = 8'h00; end
        if (cls < 0) begin
            repeat (6) @(negedge clk);
            chk("R1/R2 no entry", n_entry - b_entry, 0);
            chk("R1/R2 idle", {31'b0, busy}, 0);
        end else begin
            for (int i = 0; i < 60 && n_done == b_done; i++) @(negedge clk);
            repeat (3) @(negedge clk);
            c = ccs;
            if (cls == 1) c[30] = 1'b0;
            exp_ccs = {c[31:30], c[19:0], 10'b0};
            exp_addr = ebp + {22'b0, vec, 2'b00};
            chk("R12 single entry", n_entry - b_entry, 1);
            chk("R11 single done", n_done - b_done, 1);
            chk("R4 exs word", m_exs, {16'b0, vec, 8'b0});
            chk("R7 ccs push", m_ccs, exp_ccs);
            if (cls == 1) begin
                chk("R2 nrp value", m_nrp, pc);
                chk("R2 erp untouched", n_erp - b_erp, 0);
            end else begin
                chk("R3 R5 erp value", m_erp, pc - {29'b0, t_ds});
                chk("R3 nrp untouched", n_nrp - b_nrp, 0);
            end
            if (ccs[5]) begin
                chk("R6 usp", m_usp, sp);
                chk("R6 sp", m_sp, ksp);
            end else begin
                chk("R6 no swap", (n_usp - b_usp) + (n_sp - b_sp), 0);
            end
            chk("R8 table addr", m_addr, exp_addr);
            chk("R8 new pc", m_pc, mem_word(exp_addr));
            chk("R11 idle after", {31'b0, busy}, 0);
        end
    endtask

    task automatic set_case(input bit i, input bit n, input bit b, input bit f,
                            input bit lk, input logic [2:0] d);
        t_irq = i; t_nmi = n; t_brk = b; t_flt = f; t_lock = lk; t_ds = d;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1; irq_req = 0; nmi_req = 0; brk_req = 0; flt_req = 0; irq_lock = 0;
        ds_ld = 0; ds_val = 0; irq_vec = 8'h21; trap_vec = 8'h05; fault_vec = 8'h0E;
        pc = 32'h0000_4000; ccs = 32'h4000_0010; sp = 32'h0001_0000;
        ksp = 32'h0002_0000; ebp = 32'h0000_8000;
        repeat (3) @(negedge clk);
        // R13 reset state
        chk("R13 busy", {31'b0, busy}, 0);
        chk("R13 strobes", {22'b0, erp_we, nrp_we, exs_we, ccs_we, usp_we, sp_we,
                            rd_req, pc_we, done, busy}, 0);
        rst = 0;

        // R3 plain interrupt, supervisor mode
        set_case(1, 0, 0, 0, 0, 0); do_case(0);
        // R1 enable clear
        ccs = 32'h4000_0000; set_case(1, 0, 0, 0, 0, 0); do_case(0);
        // R1 locked
        ccs = 32'h4000_0010; set_case(1, 0, 0, 0, 1, 0); do_case(0);
        // R2 NMI with M clear
        ccs = 32'h0000_0030; set_case(0, 1, 0, 0, 0, 0); do_case(0);
        // R2 NMI taken, user mode
        ccs = 32'hC00F_F3F5; set_case(0, 1, 0, 0, 0, 0); do_case(0);
        // R9 maskable beats NMI
        ccs = 32'h4000_0010; set_case(1, 1, 0, 0, 0, 0); do_case(0);
        // R9 fault beats break and interrupts, R5 rewind
        set_case(1, 1, 1, 1, 0, 3'd4); do_case(0);
        // R5 offset cleared after use
        set_case(0, 0, 1, 0, 0, 0); do_case(0);
        // R12 extra requests during busy ignored
        set_case(0, 0, 1, 0, 0, 0); do_case(1);
        // R13 reset clears stored offset
        @(negedge clk); ds_val = 3'd2; ds_ld = 1;
        @(negedge clk); ds_ld = 0; rst = 1;
        @(negedge clk); rst = 0;
        set_case(1, 0, 0, 0, 0, 0); do_case(0);

        // random sweep
        for (int k = 0; k < 60; k++) begin
            int sel;
            sel = $urandom % 4;
            pc = $urandom & 32'hFFFF_FFFE; sp = $urandom; ksp = $urandom;
            ebp = $urandom & 32'hFFFF_FC00;
            irq_vec = $urandom; trap_vec = $urandom; fault_vec = $urandom;
            ccs = $urandom;
            if (sel == 0) ccs[4] = 1'b1;
            if (sel == 1) ccs[30] = 1'b1;
            set_case(sel == 0, sel == 1, sel == 2, sel == 3, 0, 3'($urandom % 5));
            do_case(k % 7 == 0);
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule